// File: doc/BRIEF.md
# Ring-Feedback Triple-Redundant Symbol Corrector

This block takes three redundant copies of one M-ary symbol and produces three corrected copies. It is a clocked model of three multi-valued C-element cells joined in a ring. Each cell stores one output symbol. A cell loads a new value only when the two values it compares are equal, and it then takes that common value. When they differ, it keeps its stored value. The rule makes no use of a majority, so it works for any number of logic levels.

A phase input selects one of two phases. In the setup phase, each cell is preloaded with the input of its ring neighbour, which rotates the three inputs onto the outputs. In the restoration phase, each cell compares its own input with the stored output of the preceding cell in the ring. No cell ever compares against its own output. A single input that was wrong at setup is overwritten. Once the three outputs agree, errors on any number of inputs cannot disturb them.

Fault-injection inputs can invert or replace the stored state of any cell for one clock. They model persistent upsets, and the ring then restores the corrupted cell.

Top module: `rfb_corrector`

## Requirements
- R1: In the restoration phase, a cell whose two compared symbols are equal takes that symbol at the next clock edge. A cell whose compared symbols differ keeps its stored symbol.
- R2: In the setup phase (phase = 0), the next clock edge loads y1 with x3, y2 with x1 and y3 with x2.
- R3: In the restoration phase (phase = 1), cell 1 compares x1 with y1's ring predecessor y3, cell 2 compares x2 with y1, and cell 3 compares x3 with y2.
- R4: After setup with exactly one wrong input, a single restoration edge makes all three outputs equal the correct symbol. This holds even if the wrong input stays wrong.
- R5: Once the three outputs agree during restoration, input errors on one, two or all three inputs leave every output unchanged.
- R6: The outputs are registered. An input change becomes visible only after the next rising clock edge.
- R7: An active-low synchronous reset clears all three outputs to symbol 0. It has priority over phase and fault injection.
- R8: When upsetEn[i] = 1 and upsetReplace = 0, cell i+1's stored symbol is bit-inverted at that edge. This overrides the phase behaviour.
- R9: When upsetEn[i] = 1 and upsetReplace = 1, cell i+1's stored symbol is replaced by upsetSym at that edge.
- R10: During restoration with correct inputs, a single upset cell is restored to the correct symbol at the following clock edge, well within one ring traversal.
- R11: The symbol width is ceil(log2(LEVELS)), with a minimum of 1. The behaviour holds for every level count, as checked with the default LEVELS = 5 (3-bit symbols).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 1 | 0 = setup (rotated preload), 1 = restoration |
| x1 | input | SYM_W | Redundant input copy 1 |
| x2 | input | SYM_W | Redundant input copy 2 |
| x3 | input | SYM_W | Redundant input copy 3 |
| upsetEn | input | 3 | Per-cell fault injection enable, bit i selects cell i+1 |
| upsetReplace | input | 1 | 0 = invert stored bits, 1 = replace with upsetSym |
| upsetSym | input | SYM_W | Replacement symbol for injected upsets |
| y1 | output | SYM_W | Corrected output copy 1 |
| y2 | output | SYM_W | Corrected output copy 2 |
| y3 | output | SYM_W | Corrected output copy 3 |

## Verification
The assertions assume that every input symbol lies below LEVELS, so that each input is a legal code. Injected upsets are the only way a stored symbol can leave that range. The properties about setup loading and settled stability also assume that no upset is being injected in the same cycle. The bench draws random symbols only from the range 0 to LEVELS-1 and keeps the replacement symbol in range as well. It treats inverted states, which may fall out of range, as legitimate stored values that the ring must then repair.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  // Strobes sent from the phase control to the cell datapath.
  typedef struct packed {
    logic clear;    // synchronous clear to symbol 0
    logic setup;    // rotated preload of the inputs
    logic restore;  // C-element comparison against ring predecessor
  } rfb_strobe_t;

endpackage

// File: rtl/rfb_ctrl.sv
module rfb_ctrl
  import rfb_pkg::*;
(
  input  logic        rst_n,
  input  logic        phase,
  output rfb_strobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.clear   = !rst_n;
    strobe.setup   = rst_n && !phase;
    strobe.restore = rst_n && phase;
  end

endmodule

// File: rtl/rfb_cell.sv
module rfb_cell
  import rfb_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rfb_strobe_t      strobe,
  input  logic [SYM_W-1:0] xIn,       // own redundant input
  input  logic [SYM_W-1:0] nbrIn,     // stored output of ring predecessor
  input  logic [SYM_W-1:0] shiftIn,   // rotated input for setup
  input  logic             upsetEn,
  input  logic             upsetReplace,
  input  logic [SYM_W-1:0] upsetSym,
  output logic [SYM_W-1:0] stateQ
);

  logic [SYM_W-1:0] stateD;
  logic             agree;

  assign agree = (xIn == nbrIn);

  always_comb begin
    stateD = stateQ;
    if (strobe.clear)
      stateD = '0;
    else if (upsetEn)
      stateD = upsetReplace ? upsetSym : ~stateQ;
    else if (strobe.setup)
      stateD = shiftIn;
    else if (strobe.restore && agree)
      stateD = xIn;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
  end

  AST_HOLD_ON_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.restore && !upsetEn && (xIn != nbrIn)) |=> (stateQ == $past(stateQ))); // R1

  AST_LOAD_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.restore && !upsetEn && (xIn == nbrIn)) |=> (stateQ == $past(xIn))); // R1

  AST_UPSET_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (upsetEn && !upsetReplace) |=> (stateQ == ~$past(stateQ))); // R8

  AST_UPSET_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (upsetEn && upsetReplace) |=> (stateQ == $past(upsetSym))); // R9

endmodule

// File: rtl/rfb_datapath.sv
module rfb_datapath
  import rfb_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int SYM_W  = 3,
  parameter int NCELLS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  rfb_strobe_t                  strobe,
  input  logic [NCELLS-1:0][SYM_W-1:0] xVec,
  input  logic [NCELLS-1:0]            upsetEn,
  input  logic                         upsetReplace,
  input  logic [SYM_W-1:0]             upsetSym,
  output logic [NCELLS-1:0][SYM_W-1:0] yVec
);

  // Cell i compares against the cell before it in the ring, so no
  // cell ever sees its own output.
  for (genvar gi = 0; gi < NCELLS; gi++) begin : g_cell
    localparam int PREV = (gi + NCELLS - 1) % NCELLS;
    rfb_cell #(.SYM_W(SYM_W)) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe       (strobe),
      .xIn          (xVec[gi]),
      .nbrIn        (yVec[PREV]),
      .shiftIn      (xVec[PREV]),
      .upsetEn      (upsetEn[gi]),
      .upsetReplace (upsetReplace),
      .upsetSym     (upsetSym),
      .stateQ       (yVec[gi])
    );
  end

  logic allAgree;
  assign allAgree = (yVec[0] == yVec[1]) && (yVec[1] == yVec[2]);

  always @(posedge clk) begin
    if (rst_n) begin
      AST_INPUT_RANGE: assert (int'(xVec[0]) < LEVELS && int'(xVec[1]) < LEVELS
                               && int'(xVec[2]) < LEVELS); // R11
    end
  end

  AST_SETUP_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.setup && upsetEn == '0) |=>
      (yVec[0] == $past(xVec[2]) && yVec[1] == $past(xVec[0])
       && yVec[2] == $past(xVec[1]))); // R2

  AST_SETTLED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.restore && upsetEn == '0 && allAgree) |=> $stable(yVec)); // R5

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk)
    $onehot(strobe)); // R7

endmodule

// File: rtl/rfb_corrector.sv
module rfb_corrector
  import rfb_pkg::*;
#(
  parameter int  LEVELS = 5,
  localparam int SYM_W  = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase,
  input  logic [SYM_W-1:0] x1,
  input  logic [SYM_W-1:0] x2,
  input  logic [SYM_W-1:0] x3,
  input  logic [2:0]       upsetEn,
  input  logic             upsetReplace,
  input  logic [SYM_W-1:0] upsetSym,
  output logic [SYM_W-1:0] y1,
  output logic [SYM_W-1:0] y2,
  output logic [SYM_W-1:0] y3
);

  localparam int NCELLS = 3;

  rfb_strobe_t                  strobe;
  logic [NCELLS-1:0][SYM_W-1:0] xVec;
  logic [NCELLS-1:0][SYM_W-1:0] yVec;

  assign xVec = {x3, x2, x1};
  assign y1   = yVec[0];
  assign y2   = yVec[1];
  assign y3   = yVec[2];

  rfb_ctrl u_ctrl (
    .rst_n  (rst_n),
    .phase  (phase),
    .strobe (strobe)
  );

  rfb_datapath #(.LEVELS(LEVELS), .SYM_W(SYM_W), .NCELLS(NCELLS)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .xVec         (xVec),
    .upsetEn      (upsetEn),
    .upsetReplace (upsetReplace),
    .upsetSym     (upsetSym),
    .yVec         (yVec)
  );

endmodule

// File: tb/rfb_corrector_tb.sv
`timescale 1ns/1ps
module rfb_corrector_tb;

  localparam int LEVELS = 5;
  localparam int W      = 3;
  localparam int MASK   = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         phase = 1'b0;
  logic [W-1:0] x1 = '0, x2 = '0, x3 = '0;
  logic [2:0]   upsetEn = '0;
  logic         upsetReplace = 1'b0;
  logic [W-1:0] upsetSym = '0;
  logic [W-1:0] y1, y2, y3;

  int total = 0;
  int bad = 0;
  int refY[3];
  bit finished = 0;

  always #10 clk = ~clk;

  rfb_corrector #(.LEVELS(LEVELS)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .x1(x1), .x2(x2), .x3(x3),
    .upsetEn(upsetEn), .upsetReplace(upsetReplace), .upsetSym(upsetSym),
    .y1(y1), .y2(y2), .y3(y3)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input int a, input int b, input int c);
    check({req, " y1"}, int'(y1), a);
    check({req, " y2"}, int'(y2), b);
    check({req, " y3"}, int'(y3), c);
  endtask

  // One clock: drive at negedge, advance the behavioural model at the edge,
  // compare at the following negedge.
  task automatic step(input bit rs, input bit ph, input int a, input int b, input int c,
                      input int up = 0, input bit rep = 0, input int sym = 0);
    int xs[3];
    int nxt[3];
    rst_n = rs; phase = ph;
    x1 = W'(a); x2 = W'(b); x3 = W'(c);
    upsetEn = 3'(up); upsetReplace = rep; upsetSym = W'(sym);
    xs[0] = a; xs[1] = b; xs[2] = c;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      int p;
      p = (i == 0) ? 2 : i - 1;
      if (!rs) nxt[i] = 0;
      else if (up[i]) nxt[i] = rep ? sym : (~refY[i]) & MASK;
      else if (!ph) nxt[i] = xs[p];
      else if (xs[i] == refY[p]) nxt[i] = xs[i];
      else nxt[i] = refY[i];
    end
    refY = nxt;
    @(negedge clk);
    checkAll("R1 model", refY[0], refY[1], refY[2]);
  endtask

  initial begin
    @(negedge clk);
    step(0, 0, 1, 2, 3);
    step(0, 1, 4, 4, 4, 7);
    checkAll("R7 reset clears and beats upset", 0, 0, 0);

    // R2 rotated preload
    step(1, 0, 1, 2, 3);
    checkAll("R2 setup rotation", 3, 1, 2);

    // R6 registered: new inputs not visible before the edge
    x1 = 3'd4; x2 = 3'd0; x3 = 3'd0; #1;
    checkAll("R6 no change before edge", 3, 1, 2);

    // R3 pairing: y=(3,1,2); x1=2 matches y3, x2=0 vs y1 differs, x3=1 matches y2
    step(1, 1, 2, 0, 1);
    checkAll("R3 ring pairing", 2, 1, 1);

    // R4 single wrong input at setup, each position
    for (int w = 0; w < 3; w++) begin
      int v[3];
      v[0] = 3; v[1] = 3; v[2] = 3; v[w] = 1;
      step(1, 0, v[0], v[1], v[2]);
      step(1, 1, v[0], v[1], v[2]);
      checkAll("R4 single setup error corrected", 3, 3, 3);
    end

    // R5 settled outputs ignore input errors
    step(1, 1, 3, 3, 3);
    step(1, 1, 1, 3, 3); checkAll("R5 single error", 3, 3, 3);
    step(1, 1, 0, 4, 3); checkAll("R5 double error", 3, 3, 3);
    step(1, 1, 4, 4, 4); checkAll("R5 triple same error", 3, 3, 3);
    step(1, 1, 0, 1, 2); checkAll("R5 triple distinct error", 3, 3, 3);

    // R8 invert cell 2 (3 -> 4), R10 repaired next edge
    step(1, 1, 3, 3, 3, 3'b010, 0);
    checkAll("R8 invert upset", 3, 4, 3);
    step(1, 1, 3, 3, 3);
    checkAll("R10 upset repaired", 3, 3, 3);

    // R9 replace cell 1 with 0, R10 repaired
    step(1, 1, 3, 3, 3, 3'b001, 1, 0);
    checkAll("R9 replace upset", 0, 3, 3);
    step(1, 1, 3, 3, 3);
    checkAll("R10 replace repaired", 3, 3, 3);

    // R11 all levels pass through setup and settle
    for (int s = 0; s < LEVELS; s++) begin
      step(1, 0, s, s, s);
      step(1, 1, s, s, s);
      checkAll("R11 level settles", s, s, s);
    end

    // Random run against the model (R1)
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r > 2, r < 60 ? 1'b1 : (r < 75 ? 1'b0 : 1'b1),
           $urandom_range(0, LEVELS - 1), $urandom_range(0, LEVELS - 1),
           $urandom_range(0, LEVELS - 1),
           (r % 9 == 0) ? int'($urandom_range(1, 7)) : 0,
           r[0], $urandom_range(0, LEVELS - 1));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule